// File: doc/BRIEF.md
# Serial Converter Command Receiver

This block takes a write-only, three-wire serial stream (an active-low frame select, a serial clock and a data line) and turns it into parallel command words for a four-channel digital-to-analog converter core. Each frame carries one 24-bit word, sent most significant bit first. The receiver splits the word into an 8-bit control byte and a 16-bit data word. It also keeps a 16-bit output code register that follows the data word of every completed command.

The three serial lines are oversampled by a system clock that runs at least four times faster than the serial clock. Each line passes through a two-flop synchronizer, and edges are detected in the system clock domain. The command is issued as soon as the 24th falling serial clock edge is seen, without waiting for the frame to close. After that, further clocks in the same frame are ignored. If the frame select rises before the 24th bit, the frame is dropped.

An active-low asynchronous reset clears the receiver. While it is held, the output code is preset to zero-scale or midscale, chosen by a reset-select input.

Top module: `dacrx_top`

## Requirements
- R1: While `rst_n` is low and afterwards until the first command, `cmd_valid` is 0 and `held_code` equals 16'h8000 if `rst_mid` is 1, or 16'h0000 if `rst_mid` is 0.
- R2: Bits are captured on falling edges of `sclk`, first bit as word bit 23. `cmd_ctrl` holds word bits 23..16 and `cmd_data` holds bits 15..0. The control byte is passed through unchanged: load bits sit at `cmd_ctrl[5:4]`, the channel select at `cmd_ctrl[2:1]` and the power-down bit at `cmd_ctrl[0]`.
- R3: A frame of 24 falling `sclk` edges gives exactly one single-cycle `cmd_valid` pulse. The pulse is issued while `sel_n` is still low, without a rising edge of `sel_n`.
- R4: Falling `sclk` edges after the 24th in the same frame produce no further pulse. They leave `cmd_ctrl` and `cmd_data` unchanged. These two outputs change only in a cycle where `cmd_valid` is 1.
- R5: If `sel_n` rises before the 24th falling edge, no pulse occurs and `held_code` is unchanged. The next frame starts counting again from bit 23.
- R6: After a complete frame, clocks given while `sel_n` stays low produce no command. A new frame is accepted only after a fresh falling edge of `sel_n`.
- R7: In the cycle after a `cmd_valid` pulse, `held_code` equals the `cmd_data` of that pulse. At all other times `held_code` keeps its value.
- R8: Serial activity while `rst_n` is low produces no command and leaves `held_code` at its preset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_mid | input | 1 | Reset preset select: 1 = midscale, 0 = zero-scale |
| sel_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, idles high, data taken on falling edge |
| sdi | input | 1 | Serial data, MSB first |
| cmd_valid | output | 1 | One-cycle pulse for a completed 24-bit command |
| cmd_ctrl | output | 8 | Control byte of the last command |
| cmd_data | output | 16 | Data word of the last command |
| held_code | output | 16 | Held output code register |

## Verification
The main function is tried with several words: all zeros, all ones, and mixed patterns whose control byte marks particular field positions. Together these separate a correct MSB-first capture from bit reversal, a shifted split point and stuck bits. Frames with extra clocks, an early abort, a frame select left low with extra clocks, and a frame sent during reset are each followed by a normal frame. That tells apart a receiver that locks and re-arms properly from one that keeps shifting, keeps a stale bit count, or accepts input while in reset. The reset preset is checked for both settings of the select input.

// File: rtl/dacrx_pkg.sv
package dacrx_pkg;

    localparam int WORD_W = 24;
    localparam int CTRL_W = 8;
    localparam int DATA_W = WORD_W - CTRL_W;
    localparam int CNT_W  = $clog2(WORD_W);

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [DATA_W-1:0] data;
    } cmd_t;

    typedef enum logic [1:0] {
        RX_IDLE   = 2'd0,
        RX_SHIFT  = 2'd1,
        RX_LOCKED = 2'd2
    } rx_state_e;

    // Preset code: top bit set for midscale, all zeros for zero-scale.
    function automatic logic [DATA_W-1:0] preset_code(input logic mid);
        logic [DATA_W-1:0] c;
        c = '0;
        c[DATA_W-1] = mid;
        return c;
    endfunction

endpackage

// File: rtl/dacrx_sync.sv
module dacrx_sync #(
    parameter int N_LINES = 3,
    parameter int STAGES = 2,
    parameter logic [N_LINES-1:0] IDLE = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] din,
    output logic [N_LINES-1:0] lvl
);

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {STAGES{IDLE[g]}};
            end else begin
                chain <= {chain[STAGES-2:0], din[g]};
            end
        end

        assign lvl[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/dacrx_frame.sv
module dacrx_frame
    import dacrx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_lvl,
    input  logic sck_lvl,
    input  logic sdi_lvl,
    output logic cmd_valid,
    output cmd_t cmd
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    rx_state_e           state, nxt_state;
    logic [CNT_W-1:0]    cnt, nxt_cnt;
    logic [WORD_W-2:0]   sr, nxt_sr;
    logic                sel_q, sck_q;
    logic                sel_fall, sel_rise, sck_fall;
    logic                done;

    assign sel_fall = sel_q & ~sel_lvl;
    assign sel_rise = ~sel_q & sel_lvl;
    assign sck_fall = sck_q & ~sck_lvl;

    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        nxt_sr    = sr;
        done      = 1'b0;
        if (sel_fall) begin
            nxt_state = RX_SHIFT;
            nxt_cnt   = '0;
        end else if (sel_rise) begin
            nxt_state = RX_IDLE;
        end else if (state == RX_SHIFT && sck_fall) begin
            if (cnt == LAST) begin
                nxt_state = RX_LOCKED;
                done      = 1'b1;
            end else begin
                nxt_sr  = {sr[WORD_W-3:0], sdi_lvl};
                nxt_cnt = cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            cnt       <= '0;
            sr        <= '0;
            sel_q     <= 1'b1;
            sck_q     <= 1'b1;
            cmd_valid <= 1'b0;
            cmd       <= '0;
        end else begin
            state     <= nxt_state;
            cnt       <= nxt_cnt;
            sr        <= nxt_sr;
            sel_q     <= sel_lvl;
            sck_q     <= sck_lvl;
            cmd_valid <= done;
            if (done) begin
                cmd <= cmd_t'({sr, sdi_lvl});
            end
        end
    end

endmodule

// File: rtl/dacrx_hold.sv
module dacrx_hold
    import dacrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_mid,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= preset_code(rst_mid);
        end else if (load) begin
            q <= din;
        end
    end

endmodule

// File: rtl/dacrx_top.sv
module dacrx_top
    import dacrx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_mid,
    input  logic              sel_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              cmd_valid,
    output logic [CTRL_W-1:0] cmd_ctrl,
    output logic [DATA_W-1:0] cmd_data,
    output logic [DATA_W-1:0] held_code
);

    localparam int LN_SEL = 0;
    localparam int LN_SCK = 1;
    localparam int LN_SDI = 2;
    localparam int N_LN   = 3;

    logic [N_LN-1:0] raw, lvl;
    cmd_t            cmd;

    assign raw[LN_SEL] = sel_n;
    assign raw[LN_SCK] = sclk;
    assign raw[LN_SDI] = sdi;

    dacrx_sync #(
        .N_LINES (N_LN),
        .STAGES  (SYNC_STAGES),
        .IDLE    (3'b011)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw),
        .lvl   (lvl)
    );

    dacrx_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_lvl   (lvl[LN_SEL]),
        .sck_lvl   (lvl[LN_SCK]),
        .sdi_lvl   (lvl[LN_SDI]),
        .cmd_valid (cmd_valid),
        .cmd       (cmd)
    );

    assign cmd_ctrl = cmd.ctrl;
    assign cmd_data = cmd.data;

    dacrx_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_mid (rst_mid),
        .load    (cmd_valid),
        .din     (cmd.data),
        .q       (held_code)
    );

endmodule

// File: rtl/dacrx_chk.sv
module dacrx_chk
    import dacrx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [CTRL_W-1:0] cmd_ctrl,
    input logic [DATA_W-1:0] cmd_data,
    input logic [DATA_W-1:0] held_code
);

    // R3
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R7
    held_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> held_code == $past(cmd_data));

    // R7
    held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(held_code));

    // R4
    cmd_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ctrl != $past(cmd_ctrl) || cmd_data != $past(cmd_data)) |-> cmd_valid);

    // R8
    always @(negedge clk) begin
        if (!rst_n) begin
            rst_quiet_chk: assert (!cmd_valid);
        end
    end

endmodule

bind dacrx_top dacrx_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ctrl  (cmd_ctrl),
    .cmd_data  (cmd_data),
    .held_code (held_code)
);

// File: tb/dacrx_top_tb_top.sv
module dacrx_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n, rst_mid, sel_n, sclk, sdi;
    logic        cmd_valid;
    logic [7:0]  cmd_ctrl;
    logic [15:0] cmd_data, held_code;

    int n_vec = 0;
    int n_err = 0;
    bit finished = 0;
    logic [23:0] exp_q[$];
    bit          hold_pending = 0;
    logic [15:0] hold_exp;

    always #(CLK_PERIOD/2) clk = ~clk;

    dacrx_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_mid   (rst_mid),
        .sel_n     (sel_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .cmd_valid (cmd_valid),
        .cmd_ctrl  (cmd_ctrl),
        .cmd_data  (cmd_data),
        .held_code (held_code)
    );

    task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_vec++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compares every command pulse against the scoreboard queue.
    always @(negedge clk) begin
        if (hold_pending) begin
            check(held_code == hold_exp, "R7 held code load", {8'h0, held_code}, {8'h0, hold_exp});
            hold_pending = 0;
        end
        if (rst_n && cmd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3/R4/R5/R6 unexpected command", {cmd_ctrl, cmd_data}, 24'h0);
            end else begin
                logic [23:0] w;
                w = exp_q.pop_front();
                check({cmd_ctrl, cmd_data} == w, "R2 captured word", {cmd_ctrl, cmd_data}, w);
                hold_pending = 1;
                hold_exp = w[15:0];
            end
        end
    end

    task automatic wait_sys(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sck_bit(input logic b);
        sdi = b;
        wait_sys(HALF);
        sclk = 1'b0;
        wait_sys(HALF);
        sclk = 1'b1;
    endtask

    task automatic frame(input logic [23:0] w, input int nbits, input bit expect_cmd, input bit end_high);
        if (expect_cmd) exp_q.push_back(w);
        sel_n = 1'b0;
        wait_sys(HALF);
        for (int i = 0; i < nbits; i++) begin
            if (i < 24) sck_bit(w[23-i]);
            else        sck_bit(i[0]);
        end
        wait_sys(HALF);
        if (end_high) sel_n = 1'b1;
        wait_sys(2*HALF);
    endtask

    initial begin
        #(CLK_PERIOD*50000);
        if (!finished) begin
            n_vec++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        sel_n = 1'b1; sclk = 1'b1; sdi = 1'b0; rst_mid = 1'b0; rst_n = 1'b0;
        wait_sys(5);
        // R1 zero-scale preset and quiet strobe
        check(held_code == 16'h0000, "R1 zero preset", {8'h0, held_code}, 24'h0);
        check(cmd_valid == 1'b0, "R1 strobe low in reset", {23'h0, cmd_valid}, 24'h0);
        rst_mid = 1'b1;
        wait_sys(3);
        check(held_code == 16'h8000, "R1 midscale preset", {8'h0, held_code}, 24'h8000);
        rst_n = 1'b1;
        wait_sys(5);
        check(held_code == 16'h8000, "R1 preset kept after release", {8'h0, held_code}, 24'h8000);

        // R2 several patterns
        frame(24'h3A5AC3, 24, 1, 1);
        check(held_code == 16'h5AC3, "R7 after frame", {8'h0, held_code}, 24'h5AC3);
        frame(24'h000000, 24, 1, 1);
        frame(24'hFFFFFF, 24, 1, 1);
        frame(24'h158001, 24, 1, 1);
        check(cmd_ctrl[2:1] == 2'b10, "R2 channel field", {22'h0, cmd_ctrl[2:1]}, 24'h2);
        check(cmd_ctrl[5:4] == 2'b01, "R2 load field", {22'h0, cmd_ctrl[5:4]}, 24'h1);
        check(cmd_ctrl[0] == 1'b1, "R2 power-down bit", {23'h0, cmd_ctrl[0]}, 24'h1);

        // R4 extra clocks after the 24th
        frame(24'h241234, 30, 1, 1);
        check({cmd_ctrl, cmd_data} == 24'h241234, "R4 extra clocks ignored", {cmd_ctrl, cmd_data}, 24'h241234);

        // R5 early abort, then a fresh frame
        frame(24'h30BEEF, 10, 0, 1);
        check(held_code == 16'h1234, "R5 abort keeps code", {8'h0, held_code}, 24'h1234);
        frame(24'h2C0F0F, 24, 1, 1);
        check(held_code == 16'h0F0F, "R5 fresh count after abort", {8'h0, held_code}, 24'h0F0F);

        // R6 select left low, more clocks, no new frame
        frame(24'h10AAAA, 24, 1, 0);
        for (int i = 0; i < 24; i++) sck_bit(~i[0]);
        wait_sys(2*HALF);
        check(held_code == 16'hAAAA, "R6 no frame without select fall", {8'h0, held_code}, 24'hAAAA);
        sel_n = 1'b1;
        wait_sys(2*HALF);
        frame(24'h115555, 24, 1, 1);
        check(held_code == 16'h5555, "R6 frame after new select fall", {8'h0, held_code}, 24'h5555);

        // R8 activity during reset
        rst_mid = 1'b0;
        rst_n = 1'b0;
        wait_sys(3);
        frame(24'h207777, 24, 0, 1);
        check(held_code == 16'h0000, "R8 reset ignores frame", {8'h0, held_code}, 24'h0);
        rst_n = 1'b1;
        wait_sys(5);
        check(held_code == 16'h0000, "R8 preset after release", {8'h0, held_code}, 24'h0);
        frame(24'h214321, 24, 1, 1);
        check(held_code == 16'h4321, "R7 after reset release", {8'h0, held_code}, 24'h4321);

        wait_sys(10);
        check(exp_q.size() == 0, "R3 all expected commands seen", 24'(exp_q.size()), 24'h0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule